// File: doc/BRIEF.md
# Timer with compare and capture

A 16-bit timer/counter with three output-compare channels and one input-capture channel. It sits behind an 8-bit register bus. The counter advances on a selected timer tick. That tick is either one of several prescaler strobes supplied from outside, or a chosen edge of an external clock pin. Each compare channel keeps a buffered value and an active value. The active value is checked against the counter on every tick. A match raises that channel's flag and drives the channel's waveform output.

The capture channel takes its trigger from a pin or from a comparator input. The trigger can pass through a four-sample noise filter. A selectable edge copies the counter into the capture register. Overflow, compare and capture flags are cleared by writing ones. Each flag has its own mask bit, and the masked flags are combined into a single interrupt line.

Software programs a counting mode, a clock source and a per-channel output action. It then reads counts and captured values through a shared high-byte latch.

Top module: `tcc_timer`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and `oc_out` is 0.
- R2: Register map: 0 CTRL0, 1 CTRL1, 2 FLAGS, 3 MASK, 4/5 counter low/high, 6/7, 8/9 and 10/11 compare A/B/C low/high, 12/13 capture low/high. A write to any odd (high) address from 5 upward only loads a shared temp byte. A write to a low address commits {temp, data} in one step. A read of a low address returns the low byte and latches the high byte into temp. A read of any high address returns temp.
- R3: CTRL0 layout is [1:0] mode, [4:2] clock select, [5] filter enable, [6] capture on rising (1) or falling (0) edge, [7] capture source comparator (1) or pin (0). Clock select 0 stops the counter. Values 1..3 count on prescaler strobes 0..2. Value 4 counts on falling edges of `ext_clk_pin` and value 5 on its rising edges, each after a two-flop synchronizer.
- R4: Mode 0 counts up on each tick and wraps from 0xFFFF to 0. The wrap sets FLAGS bit 0.
- R5: Mode 3 counts down on each tick and wraps from 0 to 0xFFFF. The wrap sets FLAGS bit 0.
- R6: In mode 1, a tick while the counter equals active compare A returns the counter to 0. Any other tick increments it.
- R7: Mode 2 counts up to active compare A, then down to 0, then up again. The tick that turns the counter at 0 sets FLAGS bit 0.
- R8: In modes 0 and 3 a compare write reaches the active copy at once. In modes 1 and 2 all active copies load from the buffers on the tick that turns or clears the counter at TOP.
- R9: A tick with the counter equal to active compare X sets FLAGS bit 1+X (A=0, B=1, C=2). It also applies the CTRL1 action in bits [2X+1:2X]: 00 holds the output at 0, 01 toggles, 10 clears, 11 sets. In mode 2, codes 10 and 11 act as stated while counting up and are inverted while counting down.
- R10: A selected edge of the selected capture source copies the counter into the capture register and sets FLAGS bit 4. The other edge, and the unselected source, have no effect.
- R11: With the filter on, the capture level follows the input only after 4 consecutive samples that differ from it. This adds 4 cycles of capture delay and rejects pulses of 3 cycles.
- R12: Writing 1 to a FLAGS bit clears it and writing 0 leaves it. `irq` is high exactly when some flag has its MASK bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (latches high byte on low reads) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| presc_tap | input | 3 | Prescaler strobes, one-cycle pulses |
| ext_clk_pin | input | 1 | External count clock |
| cap_pin | input | 1 | Capture pin |
| cmp_in | input | 1 | Comparator output used as capture source |
| oc_out | output | 3 | Waveform outputs of channels A, B, C |
| irq | output | 1 | Combined masked interrupt |

## Verification
Several things can happen on the same tick in clear-on-compare mode. The tick that meets TOP clears the counter, toggles output A and copies the buffered compare values into the active set. A new compare A value written halfway through a period must therefore leave the current period untouched and govern only the next one. The bench writes such a value mid-sweep and steps the counter one strobe at a time. It judges every count and every output level against an arithmetic model that keeps separate buffered and active values. A premature or missing load shows up as a wrong period length or a misplaced toggle.

// File: rtl/tcc_pkg.sv
`timescale 1ns/1ps
package tcc_pkg;
    localparam int W    = 16;
    localparam int NCH  = 3;
    localparam int NFLG = 8;

    localparam int F_OVF  = 0;
    localparam int F_CMP0 = 1;
    localparam int F_CAP  = 4;

    typedef enum logic [1:0] {
        MD_NORMAL = 2'd0,
        MD_CTC    = 2'd1,
        MD_PHASE  = 2'd2,
        MD_DOWN   = 2'd3
    } tcc_mode_e;

    localparam logic [3:0] A_CTRL0 = 4'd0;
    localparam logic [3:0] A_CTRL1 = 4'd1;
    localparam logic [3:0] A_FLAGS = 4'd2;
    localparam logic [3:0] A_MASK  = 4'd3;
    localparam logic [3:0] A_CNTL  = 4'd4;
    localparam logic [3:0] A_OCAL  = 4'd6;

    localparam logic [2:0] SEL_EXT_FALL = 3'd4;
    localparam logic [2:0] SEL_EXT_RISE = 3'd5;
endpackage

// File: rtl/tcc_clksel.sv
`timescale 1ns/1ps
module tcc_clksel import tcc_pkg::*; #(
    parameter int NTAP = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      sel,
    input  logic [NTAP-1:0] presc,
    input  logic            ext_pin,
    output logic            tick
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } cs_t;

    cs_t cs_q, cs_d;

    always_comb begin
        cs_d.s1   = ext_pin;
        cs_d.s2   = cs_q.s1;
        cs_d.prev = cs_q.s2;
        tick      = 1'b0;
        if (sel == SEL_EXT_FALL)
            tick = cs_q.prev & ~cs_q.s2;
        else if (sel == SEL_EXT_RISE)
            tick = cs_q.s2 & ~cs_q.prev;
        else
            for (int t = 0; t < NTAP; t++)
                if (int'(sel) == t + 1) tick = presc[t];
    end

    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
endmodule

// File: rtl/tcc_capt.sv
`timescale 1ns/1ps
module tcc_capt #(
    parameter int NF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_cmp,
    input  logic pin,
    input  logic cmp,
    input  logic flt_en,
    input  logic rise,
    output logic evt
);
    localparam int RW = $clog2(NF + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          filt;
        logic          prev;
        logic [RW-1:0] run;
    } cp_t;

    cp_t cp_q, cp_d;
    logic lvl;

    always_comb begin
        cp_d    = cp_q;
        cp_d.s1 = src_cmp ? cmp : pin;
        cp_d.s2 = cp_q.s1;
        if (cp_q.s2 != cp_q.filt) begin
            if (cp_q.run == RW'(NF - 1)) begin
                cp_d.filt = cp_q.s2;
                cp_d.run  = '0;
            end else begin
                cp_d.run = cp_q.run + 1'b1;
            end
        end else begin
            cp_d.run = '0;
        end
        lvl       = flt_en ? cp_q.filt : cp_q.s2;
        cp_d.prev = lvl;
        evt       = rise ? (lvl & ~cp_q.prev) : (~lvl & cp_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) cp_q <= '0;
        else        cp_q <= cp_d;

    // R11: the filtered level moves only after NF-1 prior differing samples
    assert_filt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_q.filt != $past(cp_q.filt)) |-> ($past(cp_q.run) == RW'(NF - 1)));
endmodule

// File: rtl/tcc_timer.sv
`timescale 1ns/1ps
module tcc_timer import tcc_pkg::*; #(
    parameter int NTAP = 3,
    parameter int NF   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [7:0]      bus_wdata,
    output logic [7:0]      bus_rdata,
    input  logic [NTAP-1:0] presc_tap,
    input  logic            ext_clk_pin,
    input  logic            cap_pin,
    input  logic            cmp_in,
    output logic [NCH-1:0]  oc_out,
    output logic            irq
);
    typedef struct packed {
        logic [7:0]              ctrl0;
        logic [7:0]              ctrl1;
        logic [NFLG-1:0]         flags;
        logic [NFLG-1:0]         mask;
        logic [W-1:0]            cnt;
        logic [W-1:0]            cap;
        logic [NCH-1:0][W-1:0]   buff;
        logic [NCH-1:0][W-1:0]   act;
        logic [7:0]              tmp;
        logic                    dir;
        logic [NCH-1:0]          wave;
    } st_t;

    st_t q, d;
    logic tick, cap_evt, cnt_wr, immed;
    tcc_mode_e mode;
    logic [W-1:0] top_v, rword;
    logic [NFLG-1:0] set_f, clr_f;

    function automatic logic [W-1:0] word_of(st_t s, logic [2:0] wi);
        logic [W-1:0] r;
        r = '0;
        if (wi == 3'd2) r = s.cnt;
        if (wi == 3'd6) r = s.cap;
        for (int i = 0; i < NCH; i++)
            if (int'(wi) == 3 + i) r = s.buff[i];
        return r;
    endfunction

    tcc_clksel #(.NTAP(NTAP)) u_clksel (
        .clk(clk), .rst_n(rst_n), .sel(q.ctrl0[4:2]),
        .presc(presc_tap), .ext_pin(ext_clk_pin), .tick(tick)
    );

    tcc_capt #(.NF(NF)) u_capt (
        .clk(clk), .rst_n(rst_n), .src_cmp(q.ctrl0[7]), .pin(cap_pin),
        .cmp(cmp_in), .flt_en(q.ctrl0[5]), .rise(q.ctrl0[6]), .evt(cap_evt)
    );

    always_comb begin
        rword = word_of(q, bus_addr[3:1]);
        case (bus_addr)
            A_CTRL0: bus_rdata = q.ctrl0;
            A_CTRL1: bus_rdata = q.ctrl1;
            A_FLAGS: bus_rdata = q.flags;
            A_MASK:  bus_rdata = q.mask;
            default: bus_rdata = bus_addr[0] ? q.tmp : rword[7:0];
        endcase
    end

    always_comb begin
        d      = q;
        mode   = tcc_mode_e'(q.ctrl0[1:0]);
        immed  = (mode == MD_NORMAL) || (mode == MD_DOWN);
        top_v  = immed ? '1 : q.act[0];
        cnt_wr = bus_wr && (bus_addr == A_CNTL);
        set_f  = '0;

        if (tick && !cnt_wr) begin
            unique case (mode)
                MD_NORMAL: begin
                    d.cnt = q.cnt + 1'b1;
                    set_f[F_OVF] = (q.cnt == '1);
                end
                MD_DOWN: begin
                    d.cnt = q.cnt - 1'b1;
                    set_f[F_OVF] = (q.cnt == '0);
                end
                MD_CTC: begin
                    if (q.cnt == top_v) begin
                        d.cnt = '0;
                        d.act = q.buff;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                    set_f[F_OVF] = (q.cnt == '1);
                end
                MD_PHASE: begin
                    if (q.dir) begin
                        if (q.cnt == '0) begin
                            d.dir = 1'b0;
                            d.cnt = q.cnt + 1'b1;
                            set_f[F_OVF] = 1'b1;
                        end else begin
                            d.cnt = q.cnt - 1'b1;
                        end
                    end else if (q.cnt >= top_v) begin
                        d.dir = 1'b1;
                        d.cnt = q.cnt - 1'b1;
                        d.act = q.buff;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            endcase
            for (int i = 0; i < NCH; i++) begin
                if (q.cnt == q.act[i]) begin
                    set_f[F_CMP0 + i] = 1'b1;
                    case (q.ctrl1[2*i +: 2])
                        2'b01:   d.wave[i] = ~q.wave[i];
                        2'b10:   d.wave[i] = (mode == MD_PHASE) && q.dir;
                        2'b11:   d.wave[i] = !((mode == MD_PHASE) && q.dir);
                        default: d.wave[i] = 1'b0;
                    endcase
                end
            end
        end
        for (int i = 0; i < NCH; i++)
            if (q.ctrl1[2*i +: 2] == 2'b00) d.wave[i] = 1'b0;

        if (cap_evt) begin
            d.cap        = q.cnt;
            set_f[F_CAP] = 1'b1;
        end

        clr_f   = (bus_wr && bus_addr == A_FLAGS) ? bus_wdata : '0;
        d.flags = (q.flags & ~clr_f) | set_f;

        if (bus_wr) begin
            case (bus_addr)
                A_CTRL0: d.ctrl0 = bus_wdata;
                A_CTRL1: d.ctrl1 = bus_wdata;
                A_MASK:  d.mask  = bus_wdata;
                default: ;
            endcase
            if (bus_addr > A_CNTL && bus_addr[0]) d.tmp = bus_wdata;
            if (cnt_wr) d.cnt = {q.tmp, bus_wdata};
            for (int i = 0; i < NCH; i++) begin
                if (bus_addr == 4'(A_OCAL + 2*i)) begin
                    d.buff[i] = {q.tmp, bus_wdata};
                    if (immed) d.act[i] = {q.tmp, bus_wdata};
                end
            end
        end
        if (bus_rd && !bus_addr[0] && bus_addr >= A_CNTL) d.tmp = rword[W-1:8];
    end

    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= '0;
        else        q <= d;

    assign oc_out = q.wave;
    assign irq    = |(q.flags & q.mask);

    // R3: without a tick or a counter write the count holds
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> (q.cnt == $past(q.cnt)));
    // R4: up-count wrap raises overflow
    assert_wrap_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && mode == MD_NORMAL && q.cnt == '1) |=> (q.cnt == '0 && q.flags[F_OVF]));
    // R5: down-count wrap raises overflow
    assert_wrap_dn_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && mode == MD_DOWN && q.cnt == '0) |=> (q.cnt == '1 && q.flags[F_OVF]));
    // R6: clear-on-compare returns to zero
    assert_ctc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && mode == MD_CTC && q.cnt == q.act[0]) |=> (q.cnt == '0));
    // R10: a capture event stores the count and the flag
    assert_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (q.cap == $past(q.cnt) && q.flags[F_CAP]));
endmodule

// File: tb/tcc_timer_tb.sv
`timescale 1ns/1ps
module tcc_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [2:0] presc_tap = '0;
    logic       ext_clk_pin = 1'b0, cap_pin = 1'b0, cmp_in = 1'b0;
    logic [2:0] oc_out;
    logic       irq;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tcc_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .presc_tap(presc_tap), .ext_clk_pin(ext_clk_pin), .cap_pin(cap_pin),
        .cmp_in(cmp_in), .oc_out(oc_out), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic wr16(input logic [3:0] a, input logic [15:0] v);
        wr(4'(a + 1), v[15:8]);
        wr(a, v[7:0]);
    endtask

    task automatic rd16(input logic [3:0] a, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(a, lo);
        rd(4'(a + 1), hi);
        v = {hi, lo};
    endtask

    task automatic step(input int t);
        @(negedge clk); presc_tap[t] = 1'b1;
        @(negedge clk); presc_tap[t] = 1'b0;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(64'd20 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R1..: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  v8;
        logic [15:0] v16;
        int cnt, act_a, buf_a, dir, ovf, wv;

        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        rd(4'd0, v8);  chk("R1 ctrl0", v8, 0);
        rd(4'd2, v8);  chk("R1 flags", v8, 0);
        rd16(4'd4, v16); chk("R1 counter", v16, 0);
        chk("R1 irq", irq, 0);
        chk("R1 oc_out", oc_out, 0);

        // R2 16-bit access through the temp byte
        wr16(4'd4, 16'hA5C3);
        rd16(4'd4, v16); chk("R2 counter write", v16, 16'hA5C3);
        wr(4'd5, 8'h11);
        rd16(4'd4, v16); chk("R2 high-only write", v16, 16'hA5C3);
        wr(4'd7, 8'h77);
        rd(4'd5, v8); chk("R2 shared temp", v8, 8'h77);

        // R3 clock select
        wr16(4'd4, 16'h0000);
        step(0); rd16(4'd4, v16); chk("R3 stopped", v16, 0);
        wr(4'd0, 8'h08);               // select strobe 1
        step(0); rd16(4'd4, v16); chk("R3 other tap ignored", v16, 0);
        step(1); rd16(4'd4, v16); chk("R3 tap1 tick", v16, 1);
        wr(4'd0, 8'h14);               // external rising
        ext_clk_pin = 1'b1; waitc(5); rd16(4'd4, v16); chk("R3 ext rise counted", v16, 2);
        ext_clk_pin = 1'b0; waitc(5); rd16(4'd4, v16); chk("R3 ext fall ignored", v16, 2);
        wr(4'd0, 8'h10);               // external falling
        ext_clk_pin = 1'b1; waitc(5); rd16(4'd4, v16); chk("R3 ext rise ignored", v16, 2);
        ext_clk_pin = 1'b0; waitc(5); rd16(4'd4, v16); chk("R3 ext fall counted", v16, 3);

        // R4 up count across wrap
        wr(4'd0, 8'h00); wr16(4'd4, 16'hFFFD); wr(4'd2, 8'hFF);
        wr(4'd0, 8'h04);
        cnt = 16'hFFFD; ovf = 0;
        for (int k = 0; k < 5; k++) begin
            step(0);
            if (cnt == 16'hFFFF) ovf = 1;
            cnt = (cnt + 1) & 16'hFFFF;
            rd16(4'd4, v16); chk("R4 up count", v16, cnt);
        end
        rd(4'd2, v8); chk("R4 overflow flag", v8[0], ovf);

        // R5 down count across wrap
        wr(4'd0, 8'h00); wr16(4'd4, 16'h0002); wr(4'd2, 8'hFF);
        wr(4'd0, 8'h07);
        cnt = 2; ovf = 0;
        for (int k = 0; k < 5; k++) begin
            step(0);
            if (cnt == 0) ovf = 1;
            cnt = (cnt - 1) & 16'hFFFF;
            rd16(4'd4, v16); chk("R5 down count", v16, cnt);
        end
        rd(4'd2, v8); chk("R5 overflow flag", v8[0], ovf);

        // R6 R8 R9 clear-on-compare with a mid-period compare write
        wr(4'd0, 8'h00); wr16(4'd6, 16'd3); wr16(4'd4, 16'd0);
        wr(4'd1, 8'h01); wr(4'd2, 8'hFF);
        wr(4'd0, 8'h05);
        cnt = 0; act_a = 3; buf_a = 3; wv = 0;
        for (int k = 0; k < 16; k++) begin
            if (k == 4) begin wr16(4'd6, 16'd5); buf_a = 5; end
            step(0);
            if (cnt == act_a) begin wv ^= 1; cnt = 0; act_a = buf_a; end
            else cnt = cnt + 1;
            rd16(4'd4, v16); chk("R6 R8 ctc count", v16, cnt);
            chk("R9 toggle output", oc_out[0], wv);
        end
        rd(4'd2, v8); chk("R9 compare A flag", v8[1], 1);

        // R7 R9 phase-correct up/down with channel B clear-up/set-down
        wr(4'd0, 8'h00); wr16(4'd6, 16'd4); wr16(4'd8, 16'd2); wr16(4'd4, 16'd0);
        wr(4'd1, 8'h08); wr(4'd2, 8'hFF);
        wr(4'd0, 8'h06);
        cnt = 0; dir = 0; ovf = 0; wv = 0;
        for (int k = 0; k < 20; k++) begin
            step(0);
            if (cnt == 2) wv = dir;
            if (dir == 1) begin
                if (cnt == 0) begin dir = 0; cnt = 1; ovf = 1; end
                else cnt = cnt - 1;
            end else if (cnt >= 4) begin dir = 1; cnt = cnt - 1; end
            else cnt = cnt + 1;
            rd16(4'd4, v16); chk("R7 phase count", v16, cnt);
            chk("R9 phase output B", oc_out[1], wv);
        end
        rd(4'd2, v8);
        chk("R7 bottom overflow", v8[0], ovf);
        chk("R9 compare B flag", v8[2], 1);

        // R12 write-one-to-clear and masked interrupt
        wr(4'd2, 8'hFF); rd(4'd2, v8); chk("R12 flags cleared", v8, 0);
        chk("R12 irq low", irq, 0);
        wr(4'd0, 8'h00); wr(4'd3, 8'h01); wr16(4'd4, 16'hFFFF);
        wr(4'd0, 8'h04); step(0);
        chk("R12 irq on overflow", irq, 1);
        wr(4'd2, 8'h02); chk("R12 zero bits keep flag", irq, 1);
        wr(4'd2, 8'h01); chk("R12 irq cleared", irq, 0);

        // R10 capture source and edge selection
        wr(4'd0, 8'h40); wr16(4'd4, 16'h1234); wr(4'd2, 8'hFF);
        cap_pin = 1'b1; waitc(6);
        rd16(4'd12, v16); chk("R10 rising pin capture", v16, 16'h1234);
        rd(4'd2, v8); chk("R10 capture flag", v8[4], 1);
        chk("R12 masked flag no irq", irq, 0);
        wr16(4'd4, 16'h2222);
        cap_pin = 1'b0; waitc(6);
        rd16(4'd12, v16); chk("R10 falling edge ignored", v16, 16'h1234);
        wr(4'd0, 8'hC0); wr16(4'd4, 16'h3333);
        cap_pin = 1'b1; waitc(6);
        rd16(4'd12, v16); chk("R10 unselected pin ignored", v16, 16'h1234);
        cmp_in = 1'b1; waitc(6);
        rd16(4'd12, v16); chk("R10 comparator capture", v16, 16'h3333);
        wr(4'd0, 8'h80); wr16(4'd4, 16'h4444);
        cmp_in = 1'b0; waitc(6);
        rd16(4'd12, v16); chk("R10 falling comparator capture", v16, 16'h4444);
        cap_pin = 1'b0; waitc(6);

        // R11 filter delay and pulse rejection
        wr(4'd0, 8'h44); presc_tap[0] = 1'b1; waitc(4);
        wr16(4'd4, 16'd0); cap_pin = 1'b1; waitc(10);
        presc_tap[0] = 1'b0;
        rd16(4'd12, v16); chk("R11 unfiltered capture time", v16, 2);
        cap_pin = 1'b0; waitc(10);
        wr(4'd0, 8'h64); presc_tap[0] = 1'b1; waitc(4);
        wr16(4'd4, 16'd0); cap_pin = 1'b1; waitc(12);
        presc_tap[0] = 1'b0;
        rd16(4'd12, v16); chk("R11 filtered capture time", v16, 6);
        cap_pin = 1'b0; waitc(10);
        wr(4'd2, 8'hFF);
        cap_pin = 1'b1; waitc(3); cap_pin = 1'b0; waitc(10);
        rd(4'd2, v8); chk("R11 3-cycle pulse rejected", v8[4], 0);
        cap_pin = 1'b1; waitc(4); cap_pin = 1'b0; waitc(10);
        rd(4'd2, v8); chk("R11 4-cycle pulse accepted", v8[4], 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule